// File: doc/BRIEF.md
# Command-Coded Serial Shift Engine

This block takes a stream of command bytes, and the payload bytes that follow them, from a byte-wide valid/ready input. It carries out synchronous serial transfers on a clock pin, a data-out pin and a data-in pin. The block does not make its own bit rate. An external rate generator gives it a one-cycle `tick` strobe for every half period, and each tick moves the serial clock by one edge. Bytes that are read back, and error replies, go into a small response buffer. That buffer drains onto a byte-wide valid/ready output.

The opcode of a transfer is a set of bit fields:

| Opcode bit | When set |
|---|---|
| 0 | data-out changes on the falling edge |
| 1 | bit mode |
| 2 | data-in is sampled on the falling edge |
| 3 | least significant bit first |
| 4 | the transfer writes |
| 5 | the transfer reads |

When bit 0 is clear, data-out changes on the rising edge. When bit 1 is clear, the transfer is in byte mode. When bit 2 is clear, data-in is sampled on the rising edge. When bit 3 is clear, the order is most significant bit first.

Three further one-byte commands exist:
- 0x84 turns on an internal loopback that feeds data-out back to the sampling logic.
- 0x85 turns the loopback off.
- 0x87 releases the response buffer.

Every other opcode gets a two-byte error reply.

Top module: `serial_cmd_engine`

## Requirements
- R1: Opcodes with bits 7:6 = 00 and bits 5:4 not both zero (0x10 to 0x3F) are transfers, decoded by the bit fields in the table above. Any opcode that is neither a transfer nor 0x84, 0x85 or 0x87 counts as unknown, for example 0x40.
- R2: In byte mode (bit 1 = 0), two length bytes follow the opcode, low byte first. A length of N moves N+1 bytes, so 0x0002 moves three bytes. When the transfer writes, each byte is taken from the input just before it is shifted.
- R3: In bit mode (bit 1 = 1), one length byte follows the opcode. Its bits 2:0 plus one give the number of bits (0 gives 1 bit, 7 gives 8 bits). When the transfer writes, one data byte follows the length byte.
- R4: With MSB-first order, data bit 7 goes out first and received bits enter at bit 0 and move upward. A partial byte of n bits therefore returns as data>>(8-n). With LSB-first order, bit 0 goes out first and received bits enter at bit 7 and move downward. A partial byte then returns as (data<<(8-n)) mod 256.
- R5: `sck` rests low. Each bit is one rising edge followed by one falling edge, and each edge uses one `tick`. `sck` changes only in a cycle where `tick` is high. Two bytes give 16 rising edges.
- R6: With bit 0 set, the first bit is driven on `sdo` before the first rising edge, and each later bit is driven at the falling edge that ends the bit before it. With bit 0 clear, each bit is driven at its own rising edge. A transfer that does not write leaves `sdo` unchanged.
- R7: Data-in is captured at the rising edge when bit 2 is 0 and at the falling edge when bit 2 is 1.
- R8: After 0x84, bits are sampled from the block's own `sdo` instead of `sdi`. After 0x85, or after reset, they are sampled from `sdi`. Only a command changes the loopback setting.
- R9: An unknown opcode produces the response byte 0xFA, followed by the opcode itself.
- R10: Responses stay in a buffer of RESP_DEPTH bytes. The buffer is released by 0x87, or when it becomes full, and stays released until it is empty. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R11: A transfer that both reads and writes returns exactly one byte for each byte shifted, in order. Each returned byte is captured while its write byte goes out. No input byte is taken while a byte is being shifted.
- R12: After reset, `out_valid`, `sck` and `sdo` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command/payload byte valid |
| in_data | input | 8 | Command/payload byte |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| out_valid | output | 1 | Response byte valid |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Consumer takes the response byte |
| tick | input | 1 | Half-period strobe from the rate generator |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
In loopback, data-out can change on the same edge at which data-in is sampled.

The bench sets this up in two ways:
- It runs transfers whose drive edge and sample edge are the same.
- It runs transfers where the first bit is driven before any edge.

It judges each case from the byte that comes back. In a second check, the bench drives `sdi` high before each rising edge and low before each falling edge. Reading 0xFF or 0x00 then shows which edge did the capture.

The bench also makes a buffer fill and an auto-release happen in the same cycle, using four unknown opcodes and no release command. It checks that all eight reply bytes arrive in order.

// File: rtl/sse_pkg.sv
package sse_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = 16;

    localparam logic [BYTE_W-1:0] OP_LOOP_ON  = 8'h84;
    localparam logic [BYTE_W-1:0] OP_LOOP_OFF = 8'h85;
    localparam logic [BYTE_W-1:0] OP_RELEASE  = 8'h87;
    localparam logic [BYTE_W-1:0] ERR_MARK    = 8'hFA;

    // fields of a transfer opcode
    typedef struct packed {
        logic rd;        // bit 5
        logic wr;        // bit 4
        logic lsb_first; // bit 3
        logic smp_fall;  // bit 2
        logic bit_mode;  // bit 1
        logic drv_fall;  // bit 0
    } xfer_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEN_LO,
        S_LEN_HI,
        S_PAYLOAD,
        S_LAUNCH,
        S_SHIFT,
        S_RESULT,
        S_ERR_MARK
    } seq_state_t;

    function automatic logic is_xfer_op(input logic [BYTE_W-1:0] op);
        return (op[7:6] == 2'b00) && (op[5:4] != 2'b00);
    endfunction

    function automatic xfer_mode_t decode_mode(input logic [BYTE_W-1:0] op);
        xfer_mode_t m;
        m.drv_fall  = op[0];
        m.bit_mode  = op[1];
        m.smp_fall  = op[2];
        m.lsb_first = op[3];
        m.wr        = op[4];
        m.rd        = op[5];
        return m;
    endfunction

endpackage

// File: rtl/sse_bit_shifter.sv
module sse_bit_shifter
    import sse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic              lsb_first,
    input  logic              smp_fall,
    input  logic              drv_fall,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [3:0]        nbits,
    input  logic              tick,
    input  logic              sdi_in,
    output logic              sck,
    output logic              sdo,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);

    logic [BYTE_W-1:0] tx_q, rx_q, tx_adv, rx_cap;
    logic [3:0]        left_q;
    logic              phase_q, act_q, sck_q, sdo_q, done_q;
    logic              wr_q, lsb_q, smpf_q, drvf_q;
    logic              next_bit;

    always_comb begin
        next_bit = lsb_q ? tx_q[0] : tx_q[BYTE_W-1];
        tx_adv   = lsb_q ? {1'b0, tx_q[BYTE_W-1:1]} : {tx_q[BYTE_W-2:0], 1'b0};
        rx_cap   = lsb_q ? {sdi_in, rx_q[BYTE_W-1:1]} : {rx_q[BYTE_W-2:0], sdi_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_q    <= '0;
            left_q  <= '0;
            phase_q <= 1'b0;
            act_q   <= 1'b0;
            sck_q   <= 1'b0;
            sdo_q   <= 1'b0;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            lsb_q   <= 1'b0;
            smpf_q  <= 1'b0;
            drvf_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                wr_q    <= wr_en;
                lsb_q   <= lsb_first;
                smpf_q  <= smp_fall;
                drvf_q  <= drv_fall;
                rx_q    <= '0;
                left_q  <= nbits;
                phase_q <= 1'b0;
                act_q   <= 1'b1;
                if (wr_en && drv_fall) begin
                    // first bit goes out before the first rising edge
                    sdo_q <= lsb_first ? tx_byte[0] : tx_byte[BYTE_W-1];
                    tx_q  <= lsb_first ? {1'b0, tx_byte[BYTE_W-1:1]}
                                       : {tx_byte[BYTE_W-2:0], 1'b0};
                end else begin
                    tx_q <= tx_byte;
                end
            end else if (act_q && tick) begin
                if (!phase_q) begin
                    // rising edge
                    sck_q   <= 1'b1;
                    phase_q <= 1'b1;
                    if (wr_q && !drvf_q) begin
                        sdo_q <= next_bit;
                        tx_q  <= tx_adv;
                    end
                    if (!smpf_q) rx_q <= rx_cap;
                end else begin
                    // falling edge closes the bit
                    sck_q   <= 1'b0;
                    phase_q <= 1'b0;
                    left_q  <= left_q - 4'd1;
                    if (wr_q && drvf_q && (left_q != 4'd1)) begin
                        sdo_q <= next_bit;
                        tx_q  <= tx_adv;
                    end
                    if (smpf_q) rx_q <= rx_cap;
                    if (left_q == 4'd1) begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign sck     = sck_q;
    assign sdo     = sdo_q;
    assign busy    = act_q;
    assign done    = done_q;
    assign rx_byte = rx_q;

    // R5: the serial clock moves only on a tick
    assert_sck_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sck_q));

    // R5: the clock rests low outside a transfer
    assert_sck_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
        !act_q |-> !sck_q);

endmodule

// File: rtl/sse_resp_buf.sv
module sse_resp_buf
    import sse_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              release_req,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wp_q, rp_q;
    logic [CW-1:0]     cnt_q, cnt_nx;
    logic              rel_q, pop;

    assign full      = (cnt_q == CW'(DEPTH));
    assign out_valid = rel_q && (cnt_q != '0);
    assign out_data  = mem_q[rp_q];
    assign pop       = out_valid && out_ready;
    assign cnt_nx    = cnt_q + CW'(push) - CW'(pop);

    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else begin
            if (push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            if (pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
            cnt_q <= cnt_nx;
            if (release_req || (cnt_nx == CW'(DEPTH))) rel_q <= 1'b1;
            else if (cnt_nx == '0)                     rel_q <= 1'b0;
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    assert_hold_while_stalled_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/serial_cmd_engine.sv
module serial_cmd_engine
    import sse_pkg::*;
#(
    parameter int RESP_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              tick,
    output logic              sck,
    output logic              sdo,
    input  logic              sdi
);

    seq_state_t        state_q, after_byte;
    xfer_mode_t        mode_q;
    logic [LEN_W-1:0]  len_q;
    logic [3:0]        nbits_q;
    logic [BYTE_W-1:0] tx_q, err_op_q, rx_byte, push_data;
    logic              loop_q, err_second_q;
    logic              accept, push, buf_full, release_req;
    logic              sh_start, sh_busy, sh_done, sdi_eff;

    assign in_ready = (state_q == S_IDLE) || (state_q == S_LEN_LO) ||
                      (state_q == S_LEN_HI) || (state_q == S_PAYLOAD);
    assign accept      = in_valid && in_ready;
    assign sh_start    = (state_q == S_LAUNCH);
    assign release_req = accept && (state_q == S_IDLE) && (in_data == OP_RELEASE);
    assign sdi_eff     = loop_q ? sdo : sdi;
    // state after one byte has been shifted (and answered)
    assign after_byte  = (len_q == '0) ? S_IDLE : (mode_q.wr ? S_PAYLOAD : S_LAUNCH);

    always_comb begin
        push      = 1'b0;
        push_data = rx_byte;
        if (state_q == S_RESULT) begin
            push = !buf_full;
        end else if (state_q == S_ERR_MARK) begin
            push      = !buf_full;
            push_data = err_second_q ? err_op_q : ERR_MARK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            mode_q       <= '0;
            len_q        <= '0;
            nbits_q      <= '0;
            tx_q         <= '0;
            err_op_q     <= '0;
            err_second_q <= 1'b0;
            loop_q       <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (accept) begin
                    if (is_xfer_op(in_data)) begin
                        mode_q  <= decode_mode(in_data);
                        state_q <= S_LEN_LO;
                    end else if (in_data == OP_LOOP_ON) begin
                        loop_q <= 1'b1;
                    end else if (in_data == OP_LOOP_OFF) begin
                        loop_q <= 1'b0;
                    end else if (in_data != OP_RELEASE) begin
                        err_op_q     <= in_data;
                        err_second_q <= 1'b0;
                        state_q      <= S_ERR_MARK;
                    end
                end
                S_LEN_LO: if (accept) begin
                    if (mode_q.bit_mode) begin
                        len_q   <= '0;
                        nbits_q <= {1'b0, in_data[2:0]} + 4'd1;
                        state_q <= mode_q.wr ? S_PAYLOAD : S_LAUNCH;
                    end else begin
                        len_q[7:0] <= in_data;
                        state_q    <= S_LEN_HI;
                    end
                end
                S_LEN_HI: if (accept) begin
                    len_q[LEN_W-1:8] <= in_data;
                    nbits_q          <= 4'd8;
                    state_q          <= mode_q.wr ? S_PAYLOAD : S_LAUNCH;
                end
                S_PAYLOAD: if (accept) begin
                    tx_q    <= in_data;
                    state_q <= S_LAUNCH;
                end
                S_LAUNCH: state_q <= S_SHIFT;
                S_SHIFT: if (sh_done) begin
                    if (mode_q.rd) begin
                        state_q <= S_RESULT;
                    end else begin
                        state_q <= after_byte;
                        if (len_q != '0) len_q <= len_q - LEN_W'(1);
                    end
                end
                S_RESULT: if (!buf_full) begin
                    state_q <= after_byte;
                    if (len_q != '0) len_q <= len_q - LEN_W'(1);
                end
                S_ERR_MARK: if (!buf_full) begin
                    err_second_q <= !err_second_q;
                    if (err_second_q) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    sse_bit_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (sh_start),
        .wr_en     (mode_q.wr),
        .lsb_first (mode_q.lsb_first),
        .smp_fall  (mode_q.smp_fall),
        .drv_fall  (mode_q.drv_fall),
        .tx_byte   (tx_q),
        .nbits     (nbits_q),
        .tick      (tick),
        .sdi_in    (sdi_eff),
        .sck       (sck),
        .sdo       (sdo),
        .busy      (sh_busy),
        .done      (sh_done),
        .rx_byte   (rx_byte)
    );

    sse_resp_buf #(.DEPTH(RESP_DEPTH)) u_resp (
        .clk         (clk),
        .rst         (rst),
        .push        (push),
        .push_data   (push_data),
        .release_req (release_req),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .full        (buf_full)
    );

    // R11: input is never taken while a byte is on the wire
    assert_no_take_while_shifting_R11: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !sh_busy);

    // R8: loopback setting moves only when a byte is accepted
    assert_loop_static_R8: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(loop_q));

endmodule

// File: tb/sim_serial_cmd_engine.sv
module sim_serial_cmd_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, sck, sdo;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       tick = 1'b0;
    logic       sdi = 1'b0;
    logic       tick_en = 1'b1;
    logic [1:0] sdi_mode = 2'd0;   // 0: low, 1: high, 2: high before rising, low before falling
    int         tick_div = 0;
    int         total = 0;
    int         bad = 0;
    int         cyc = 0;
    int         rises = 0;

    always #10 clk = ~clk;   // 50 MHz

    serial_cmd_engine #(.RESP_DEPTH(8)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .tick(tick), .sck(sck), .sdo(sdo), .sdi(sdi)
    );

    // rate generator and external serial source
    always @(negedge clk) begin
        tick_div = tick_div + 1;
        if (tick_div == 4) begin
            tick_div = 0;
            tick = tick_en;
        end else begin
            tick = 1'b0;
        end
        case (sdi_mode)
            2'd0:    sdi = 1'b0;
            2'd1:    sdi = 1'b1;
            default: sdi = ~sck;
        endcase
    end

    always @(posedge sck) rises = rises + 1;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  sdim;
        logic [3:0]  nin;
        logic [63:0] cmd;   // first byte in the top bits
        logic [1:0]  nout;
        logic [23:0] rsp;   // first response in the top bits
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{4'd11, 2'd0, 4'd6, 64'h8431_0100_3CC3_0000, 2'd2, 24'h3CC3_00}, // R8 R11 R2 loopback two bytes
        '{4'd4,  2'd0, 4'd4, 64'h3900_00A5_0000_0000, 2'd1, 24'hA5_0000}, // R4 LSB-first byte
        '{4'd3,  2'd0, 4'd3, 64'h3303_A500_0000_0000, 2'd1, 24'h0A_0000}, // R3 R4 4 bits MSB-first
        '{4'd4,  2'd0, 4'd3, 64'h3B03_A500_0000_0000, 2'd1, 24'h50_0000}, // R4 4 bits LSB-first
        '{4'd7,  2'd0, 4'd4, 64'h3500_0096_0000_0000, 2'd1, 24'h96_0000}, // R7 sample on falling
        '{4'd7,  2'd0, 4'd4, 64'h3400_0069_0000_0000, 2'd1, 24'h69_0000}, // R7 drive rising sample falling
        '{4'd3,  2'd0, 4'd3, 64'h3307_5A00_0000_0000, 2'd1, 24'h5A_0000}, // R3 length 7 = 8 bits
        '{4'd8,  2'd1, 4'd4, 64'h8520_0000_0000_0000, 2'd1, 24'hFF_0000}, // R8 loopback off, sdi high
        '{4'd7,  2'd2, 4'd3, 64'h2000_0000_0000_0000, 2'd1, 24'hFF_0000}, // R7 rising capture
        '{4'd7,  2'd2, 4'd3, 64'h2400_0000_0000_0000, 2'd1, 24'h00_0000}, // R7 falling capture
        '{4'd4,  2'd1, 4'd2, 64'h2202_0000_0000_0000, 2'd1, 24'h07_0000}, // R4 partial MSB-first read
        '{4'd4,  2'd1, 4'd2, 64'h2A02_0000_0000_0000, 2'd1, 24'hE0_0000}, // R4 partial LSB-first read
        '{4'd9,  2'd0, 4'd1, 64'h8A00_0000_0000_0000, 2'd2, 24'hFA8A_00}, // R9 unknown opcode
        '{4'd1,  2'd0, 4'd1, 64'h4000_0000_0000_0000, 2'd2, 24'hFA40_00}, // R1 0x40 is not a transfer
        '{4'd2,  2'd1, 4'd3, 64'h2002_0000_0000_0000, 2'd3, 24'hFFFFFF},  // R2 length 2 = 3 bytes
        '{4'd6,  2'd0, 4'd7, 64'h8413_0080_2000_0000, 2'd1, 24'hFF_0000}, // R6 read leaves sdo held
        '{4'd1,  2'd0, 4'd4, 64'h8528_0000_0000_0000, 2'd1, 24'h00_0000}  // R1 read-only LSB, sdi low
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling clock edge
    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b, output bit ok);
        ok = 1'b0;
        b  = 8'h00;
        for (int i = 0; i < 4000; i++) begin
            if (out_valid) begin
                b  = out_data;
                ok = 1'b1;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        bit         ok;
        int         base;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 out_valid", {7'd0, out_valid}, 8'd0);
        chk("R12 sck", {7'd0, sck}, 8'd0);
        chk("R12 sdo", {7'd0, sdo}, 8'd0);
        chk("R12 in_ready", {7'd0, in_ready}, 8'd1);

        // table walk
        for (int r = 0; r < NVEC; r++) begin
            sdi_mode = VECS[r].sdim;
            for (int k = 0; k < int'(VECS[r].nin); k++)
                send(VECS[r].cmd[63 - 8*k -: 8]);
            send(8'h87);
            for (int k = 0; k < int'(VECS[r].nout); k++) begin
                get_byte(b, ok);
                if (!ok) b = 8'hXX;
                chk($sformatf("R%0d row %0d byte %0d", VECS[r].req, r, k),
                    b, VECS[r].rsp[23 - 8*k -: 8]);
            end
        end

        // R10: held until released, stable while stalled
        sdi_mode = 2'd1;
        send(8'h20); send(8'h00); send(8'h00);
        wait_cyc(200);
        chk("R10 held before release", {7'd0, out_valid}, 8'd0);
        out_ready = 1'b0;
        send(8'h87);
        wait_cyc(3);
        chk("R10 valid after release", {7'd0, out_valid}, 8'd1);
        chk("R10 data after release", out_data, 8'hFF);
        wait_cyc(4);
        chk("R10 valid while stalled", {7'd0, out_valid}, 8'd1);
        chk("R10 data while stalled", out_data, 8'hFF);
        out_ready = 1'b1;
        get_byte(b, ok);
        wait_cyc(3);
        chk("R10 empty after drain", {7'd0, out_valid}, 8'd0);

        // R10 R9: fill releases without a release command
        for (int k = 1; k <= 4; k++) send(8'(k));
        for (int k = 1; k <= 4; k++) begin
            get_byte(b, ok);
            chk("R9 auto-release marker", ok ? b : 8'hXX, 8'hFA);
            get_byte(b, ok);
            chk("R10 auto-release opcode", ok ? b : 8'hXX, 8'(k));
        end

        // R5: two write-only bytes give 16 rising edges
        base = rises;
        send(8'h10); send(8'h01); send(8'h00); send(8'hAA); send(8'h55);
        wait_cyc(300);
        chk("R5 rising edge count", 8'(rises - base), 8'd16);
        chk("R5 sck rests low", {7'd0, sck}, 8'd0);
        chk("R11 write-only gives no reply", {7'd0, out_valid}, 8'd0);

        // R6: drive edge timing
        send(8'h13); send(8'h00); send(8'h00);
        wait_cyc(40);
        chk("R6 sdo low after bit write", {7'd0, sdo}, 8'd0);
        tick_en = 1'b0;
        send(8'h12); send(8'h00); send(8'h80);
        wait_cyc(10);
        chk("R6 rising-drive not early", {7'd0, sdo}, 8'd0);
        chk("R5 no tick no edge", {7'd0, sck}, 8'd0);
        tick_en = 1'b1;
        wait_cyc(40);
        chk("R6 rising-drive bit out", {7'd0, sdo}, 8'd1);
        tick_en = 1'b0;
        send(8'h13); send(8'h00); send(8'h00);
        wait_cyc(10);
        chk("R6 falling-drive first bit early", {7'd0, sdo}, 8'd0);
        tick_en = 1'b1;
        wait_cyc(40);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule